// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block runs on the reference input clock and produces a signed frequency-offset code for a current-steering DAC that trims a PLL oscillator. Sweeping the oscillator slightly around its nominal frequency spreads the clock's energy across a band, which lowers the peak of its emission spectrum. The offset follows a triangle. A build-time parameter selects one of two placements. Center placement swings the code evenly above and below zero. Down placement keeps the code at or below zero, so the clock never runs above nominal.

Three static pin-level inputs configure the block. The first selects the swing depth. The second selects a band code, which sets how many input clocks one modulation cycle lasts. The third is an active-low enable. The cycle length is not fixed. It walks linearly from a minimum to a maximum count and back again over successive cycles, so that its long-run mean is the typical value for the band. When any input changes, the block restarts the triangle at zero offset and drops a ready flag. That flag stays low for a settle interval that is set by a parameter. A one-clock pulse marks the end of every triangle cycle.

Top module: `ssc_profile_gen`

## Requirements
- R1: With center placement (DOWN_SPREAD=0), offset_code stays within ±H and reaches both +H and −H in every cycle. H is SWING_LO/2 = 10 when deep_sel=0 and SWING_HI/2 = 30 when deep_sel=1. One LSB is 0.05 % of nominal.
- R2: With down placement (DOWN_SPREAD=1), offset_code stays within [−S, 0] and reaches both ends in every cycle. S is SWING_LO = 20 when deep_sel=0 and SWING_HI = 60 when deep_sel=1.
- R3: offset_code moves by at most 1 per clock. It makes exactly 2·S unit steps per modulation cycle, where S = 20 or 60. It is 0 in any cycle where period_done is high.
- R4: band_sel codes 0, 1, 2 and 3 scale the cycle length by 3, 5, 6 and 10. The first cycle after a restart lasts UNIT_MIN·mult clocks, so the first period_done is sampled high on the (UNIT_MIN·mult + 3)th clock edge after an input change.
- R5: Successive cycle lengths after a restart grow by (UNIT_MAX−UNIT_MIN)/SWEEP_STEPS·mult per cycle up to UNIT_MAX·mult, then shrink back to the minimum. No cycle lies outside [UNIT_MIN·mult, UNIT_MAX·mult].
- R6: Over any 2·SWEEP_STEPS consecutive cycles, the total length equals 2·SWEEP_STEPS times the typical length (UNIT_MIN+UNIT_MAX)/2·mult.
- R7: While mod_en_n is high, offset_code is 0 and period_done stays low. This holds from the 3rd clock edge after mod_en_n rises.
- R8: After a change on mod_en_n, deep_sel or band_sel, ready is low from the 3rd edge onward and first reads high after edge SETTLE_CLKS+3. Once high, it stays high until the next change.
- R9: While rst_n is low, offset_code is 0 and ready and period_done are low. If the inputs are all low when reset is released, ready first reads high after edge SETTLE_CLKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en_n | input | 1 | Active-low modulation enable; high forces zero offset |
| deep_sel | input | 1 | Swing depth select: 0 shallow, 1 deep |
| band_sel | input | 2 | Band code setting the cycle-length scale (3, 5, 6, 10) |
| offset_code | output | OFS_W | Signed offset code for the DAC, 0.05 % per LSB |
| ready | output | 1 | High once the settle interval after the last change has elapsed |
| period_done | output | 1 | One-clock pulse at the end of each triangle cycle |

## Verification
The bench drives both placements side by side. It first runs directed settings for each depth and the extreme bands, then a seeded random series of depth and band pairs. In every series it checks the settle timing, the first two cycle lengths, the triangle extremes and the per-cycle step count. Comparing center and down placement shows whether the bounds follow the placement parameter or only the depth. Comparing the shallow and deep settings shows whether the step count follows the swing. Long runs on bands 0 and 3 cover 32 whole cycles, and separate a correct rising-and-falling length walk from one that only rises or stalls at an end. A disable window checks that the code is held at zero and that no cycle pulses are issued.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    // largest cycle-length multiplier of any band code
    localparam int MULT_MAX = 10;

    typedef struct packed {
        logic       en_n;
        logic       deep;
        logic [1:0] band;
    } ssc_cfg_t;

    // cycle-length scale per band code (R4)
    function automatic int band_mult(input logic [1:0] band);
        case (band)
            2'd0:    return 3;
            2'd1:    return 5;
            2'd2:    return 6;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/ssc_cfg_track.sv
module ssc_cfg_track
    import ssc_pkg::*;
#(
    parameter int SETTLE_CLKS = 65536
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ssc_cfg_t cfg_in,
    output ssc_cfg_t cfg_out,
    output logic     restart,
    output logic     ready
);

    localparam int CNT_W = $clog2(SETTLE_CLKS + 1);

    typedef struct packed {
        ssc_cfg_t         sync1;
        ssc_cfg_t         sync2;
        ssc_cfg_t         cfg;
        logic [CNT_W-1:0] settle;
        logic             ready;
    } trk_t;

    trk_t st_d, st_q;
    logic change_w;

    assign change_w = (st_q.sync2 != st_q.cfg);

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = cfg_in;
        st_d.sync2 = st_q.sync1;
        st_d.cfg   = st_q.sync2;
        if (change_w) begin
            st_d.settle = CNT_W'(SETTLE_CLKS);
            st_d.ready  = 1'b0;
        end else if (st_q.settle != '0) begin
            st_d.settle = st_q.settle - 1'b1;
            st_d.ready  = (st_q.settle == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.settle <= CNT_W'(SETTLE_CLKS);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_out = st_q.cfg;
    assign restart = change_w;
    assign ready   = st_q.ready;

    assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !ready);

    assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !restart) |=> ready);

    assert_ready_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !restart && st_q.settle > CNT_W'(1)) |=> !ready);

endmodule

// File: rtl/ssc_period_sweep.sv
module ssc_period_sweep
    import ssc_pkg::*;
#(
    parameter int UNIT_MIN    = 640,
    parameter int UNIT_MAX    = 880,
    parameter int SWEEP_STEPS = 16,
    parameter int PER_W       = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       band,
    input  logic             restart,
    input  logic             wrap,
    output logic [PER_W-1:0] period_len
);

    localparam int K_W      = $clog2(SWEEP_STEPS + 1);
    localparam int INC_UNIT = (UNIT_MAX - UNIT_MIN) / SWEEP_STEPS;

    typedef struct packed {
        logic [K_W-1:0] k;
        logic           up;
    } swp_t;

    swp_t st_d, st_q;
    int   mult_w;

    assign mult_w     = band_mult(band);
    assign period_len = PER_W'(UNIT_MIN * mult_w + int'(st_q.k) * INC_UNIT * mult_w);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.k  = '0;
            st_d.up = 1'b1;
        end else if (wrap) begin
            if (st_q.up) begin
                st_d.k = st_q.k + 1'b1;
                if (st_q.k == K_W'(SWEEP_STEPS - 1)) st_d.up = 1'b0;
            end else begin
                st_d.k = st_q.k - 1'b1;
                if (st_q.k == K_W'(1)) st_d.up = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.k  <= '0;
            st_q.up <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assert_len_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (period_len >= PER_W'(UNIT_MIN * mult_w)) && (period_len <= PER_W'(UNIT_MAX * mult_w)));

    assert_sweep_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.k) <= SWEEP_STEPS);

    assert_sweep_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !restart) |=> (st_q.k != $past(st_q.k)));

endmodule

// File: rtl/ssc_tri_engine.sv
module ssc_tri_engine #(
    parameter int DOWN_SPREAD = 0,
    parameter int SWING_LO    = 20,
    parameter int SWING_HI    = 60,
    parameter int OFS_W       = 8,
    parameter int PER_W       = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    deep,
    input  logic                    active,
    input  logic                    restart,
    input  logic [PER_W-1:0]        period_len,
    output logic                    wrap,
    output logic                    done,
    output logic signed [OFS_W-1:0] offset
);

    localparam int TOP_LO = (DOWN_SPREAD != 0) ? 0 : SWING_LO / 2;
    localparam int TOP_HI = (DOWN_SPREAD != 0) ? 0 : SWING_HI / 2;
    localparam int BOT_LO = (DOWN_SPREAD != 0) ? -SWING_LO : -(SWING_LO / 2);
    localparam int BOT_HI = (DOWN_SPREAD != 0) ? -SWING_HI : -(SWING_HI / 2);
    localparam logic signed [OFS_W-1:0] ONE = 1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] acc;
        logic [OFS_W-1:0] pos;
        logic             up;
        logic             done;
    } eng_t;

    eng_t st_d, st_q;

    logic signed [OFS_W-1:0] pos_w, nxt_pos_w, top_w, bot_w;
    logic [PER_W:0]          steps2_w, acc_sum_w;
    logic                    hold_w, wrap_w, step_w;

    assign pos_w     = st_q.pos;
    assign top_w     = deep ? OFS_W'(TOP_HI) : OFS_W'(TOP_LO);
    assign bot_w     = deep ? OFS_W'(BOT_HI) : OFS_W'(BOT_LO);
    assign steps2_w  = deep ? (PER_W+1)'(2 * SWING_HI) : (PER_W+1)'(2 * SWING_LO);
    assign hold_w    = restart || !active;
    assign wrap_w    = !hold_w && (st_q.cnt == period_len - 1'b1);
    assign acc_sum_w = {1'b0, st_q.acc} + steps2_w;
    assign step_w    = (acc_sum_w >= {1'b0, period_len});
    assign nxt_pos_w = st_q.up ? (pos_w + ONE) : (pos_w - ONE);

    always_comb begin
        st_d = st_q;
        if (hold_w) begin
            st_d.cnt  = '0;
            st_d.acc  = '0;
            st_d.pos  = '0;
            st_d.up   = (DOWN_SPREAD == 0);
            st_d.done = 1'b0;
        end else begin
            st_d.cnt  = wrap_w ? '0 : st_q.cnt + 1'b1;
            st_d.done = wrap_w;
            if (step_w) begin
                st_d.acc = PER_W'(acc_sum_w - {1'b0, period_len});
                st_d.pos = nxt_pos_w;
                if (nxt_pos_w == top_w)      st_d.up = 1'b0;
                else if (nxt_pos_w == bot_w) st_d.up = 1'b1;
            end else begin
                st_d.acc = PER_W'(acc_sum_w);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.up <= (DOWN_SPREAD == 0);
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap   = wrap_w;
    assign done   = st_q.done;
    assign offset = pos_w;

    assert_in_band_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_w <= top_w) && (pos_w >= bot_w));

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hold_w) |-> ((pos_w == $past(pos_w)) || (pos_w == $past(pos_w) + ONE)
                            || (pos_w == $past(pos_w) - ONE)));

    assert_zero_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (pos_w == '0));

    assert_acc_below_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc < period_len);

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
    import ssc_pkg::*;
#(
    parameter int DOWN_SPREAD = 0,
    parameter int SETTLE_CLKS = 65536,
    parameter int UNIT_MIN    = 640,
    parameter int UNIT_MAX    = 880,
    parameter int SWEEP_STEPS = 16,
    parameter int SWING_LO    = 20,
    parameter int SWING_HI    = 60,
    parameter int OFS_W       = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mod_en_n,
    input  logic                    deep_sel,
    input  logic [1:0]              band_sel,
    output logic signed [OFS_W-1:0] offset_code,
    output logic                    ready,
    output logic                    period_done
);

    localparam int PER_W = $clog2(UNIT_MAX * MULT_MAX + 1);

    ssc_cfg_t                cfg_in_w, cfg_w;
    logic                    restart_w, wrap_w, done_w;
    logic [PER_W-1:0]        period_len_w;
    logic signed [OFS_W-1:0] eng_ofs_w;

    assign cfg_in_w = '{en_n: mod_en_n, deep: deep_sel, band: band_sel};

    ssc_cfg_track #(
        .SETTLE_CLKS(SETTLE_CLKS)
    ) u_cfg_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_in (cfg_in_w),
        .cfg_out(cfg_w),
        .restart(restart_w),
        .ready  (ready)
    );

    ssc_period_sweep #(
        .UNIT_MIN   (UNIT_MIN),
        .UNIT_MAX   (UNIT_MAX),
        .SWEEP_STEPS(SWEEP_STEPS),
        .PER_W      (PER_W)
    ) u_period_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .band      (cfg_w.band),
        .restart   (restart_w || cfg_w.en_n),
        .wrap      (wrap_w),
        .period_len(period_len_w)
    );

    ssc_tri_engine #(
        .DOWN_SPREAD(DOWN_SPREAD),
        .SWING_LO   (SWING_LO),
        .SWING_HI   (SWING_HI),
        .OFS_W      (OFS_W),
        .PER_W      (PER_W)
    ) u_tri_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .deep      (cfg_w.deep),
        .active    (!cfg_w.en_n),
        .restart   (restart_w),
        .period_len(period_len_w),
        .wrap      (wrap_w),
        .done      (done_w),
        .offset    (eng_ofs_w)
    );

    assign offset_code = cfg_w.en_n ? '0 : eng_ofs_w;
    assign period_done = done_w;

    assert_no_pulse_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_w.en_n && $past(cfg_w.en_n)) |-> !period_done);

endmodule

// File: tb/ssc_profile_gen_bench.sv
module ssc_profile_gen_bench;

    localparam int SETTLE = 50;
    localparam int UMIN   = 64;
    localparam int UMAX   = 96;
    localparam int STEPS  = 16;
    localparam int SLO    = 20;
    localparam int SHI    = 60;
    localparam int LIMIT  = 190000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, mod_en_n = 1'b0, deep_sel = 1'b0;
    logic [1:0] band_sel = 2'd0;
    logic signed [7:0] ofs_c, ofs_d;
    logic rdy_c, rdy_d, done_c, done_d;

    ssc_profile_gen #(.DOWN_SPREAD(0), .SETTLE_CLKS(SETTLE), .UNIT_MIN(UMIN), .UNIT_MAX(UMAX),
        .SWEEP_STEPS(STEPS), .SWING_LO(SLO), .SWING_HI(SHI), .OFS_W(8)) u_ssc_profile_gen (
        .clk(clk), .rst_n(rst_n), .mod_en_n(mod_en_n), .deep_sel(deep_sel), .band_sel(band_sel),
        .offset_code(ofs_c), .ready(rdy_c), .period_done(done_c));

    ssc_profile_gen #(.DOWN_SPREAD(1), .SETTLE_CLKS(SETTLE), .UNIT_MIN(UMIN), .UNIT_MAX(UMAX),
        .SWEEP_STEPS(STEPS), .SWING_LO(SLO), .SWING_HI(SHI), .OFS_W(8)) u_ssc_profile_gen_down (
        .clk(clk), .rst_n(rst_n), .mod_en_n(mod_en_n), .deep_sel(deep_sel), .band_sel(band_sel),
        .offset_code(ofs_d), .ready(rdy_d), .period_done(done_d));

    logic signed [7:0] ofs_a [2];
    logic rdy_a [2];
    logic done_a [2];
    assign ofs_a[0] = ofs_c;   assign ofs_a[1] = ofs_d;
    assign rdy_a[0] = rdy_c;   assign rdy_a[1] = rdy_d;
    assign done_a[0] = done_c; assign done_a[1] = done_d;

    int n_chk = 0, n_bad = 0;
    int cur_en_n = 0, cur_deep = 0, cur_band = 0;

    function automatic int f_mult(input int band);
        case (band) 0: return 3; 1: return 5; 2: return 6; default: return 10; endcase
    endfunction
    function automatic int f_pmin(input int band); return UMIN * f_mult(band); endfunction
    function automatic int f_pmax(input int band); return UMAX * f_mult(band); endfunction
    function automatic int f_inc(input int band);  return ((UMAX - UMIN) / STEPS) * f_mult(band); endfunction
    function automatic int f_typ(input int band);  return ((UMIN + UMAX) / 2) * f_mult(band); endfunction
    function automatic int f_swing(input int deep); return (deep != 0) ? SHI : SLO; endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply_cfg(input int en_n, input int deep, input int band);
        @(negedge clk);
        mod_en_n = en_n[0];
        deep_sel = deep[0];
        band_sel = band[1:0];
        cur_en_n = en_n; cur_deep = deep; cur_band = band;
    endtask

    // R1 R2 R3 R4 R5 R8: one restart, then two whole cycles on both placements
    task automatic run_config(input int deep_in, input int band);
        int p [2][3];
        int np [2], rise [2], mx [2], mn [2], steps [2], jumps [2], zbad [2], prev [2];
        int n, lim, deep, sw;
        deep = deep_in;
        if (deep == cur_deep && band == cur_band && cur_en_n == 0) deep = 1 - deep;
        apply_cfg(0, deep, band);
        lim = SETTLE + 3 * f_pmax(band) + 20;
        for (int d = 0; d < 2; d++) begin
            np[d] = 0; rise[d] = 0; mx[d] = -1000; mn[d] = 1000;
            steps[d] = 0; jumps[d] = 0; zbad[d] = 0; prev[d] = 0;
            for (int j = 0; j < 3; j++) p[d][j] = 0;
        end
        n = 0;
        while (n < lim && !(np[0] >= 3 && np[1] >= 3)) begin
            @(negedge clk);
            n++;
            for (int d = 0; d < 2; d++) begin
                int o, df;
                o = int'(ofs_a[d]);
                if (n >= 3 && rise[d] == 0 && rdy_a[d]) rise[d] = n;
                if (np[d] >= 1 && np[d] <= 2) begin
                    if (o > mx[d]) mx[d] = o;
                    if (o < mn[d]) mn[d] = o;
                    df = o - prev[d];
                    if (df == 1 || df == -1) steps[d]++;
                    else if (df != 0) jumps[d]++;
                end
                if (done_a[d]) begin
                    if (np[d] < 3) p[d][np[d]] = n;
                    np[d]++;
                    if (o != 0) zbad[d]++;
                end
                prev[d] = o;
            end
        end
        sw = f_swing(deep);
        for (int d = 0; d < 2; d++) begin
            check(rise[d] == SETTLE + 3, "R8", "ready rise edge", rise[d], SETTLE + 3);
            check(p[d][0] == f_pmin(band) + 3, "R4", "first cycle end edge", p[d][0], f_pmin(band) + 3);
            check(p[d][1] - p[d][0] == f_pmin(band) + f_inc(band), "R5", "second cycle length",
                  p[d][1] - p[d][0], f_pmin(band) + f_inc(band));
            check(p[d][2] - p[d][1] == f_pmin(band) + 2 * f_inc(band), "R5", "third cycle length",
                  p[d][2] - p[d][1], f_pmin(band) + 2 * f_inc(band));
            if (d == 0) begin
                check(mx[d] == sw / 2, "R1", "center top", mx[d], sw / 2);
                check(mn[d] == -(sw / 2), "R1", "center bottom", mn[d], -(sw / 2));
            end else begin
                check(mx[d] == 0, "R2", "down top", mx[d], 0);
                check(mn[d] == -sw, "R2", "down bottom", mn[d], -sw);
            end
            check(steps[d] == 4 * sw, "R3", "unit steps in two cycles", steps[d], 4 * sw);
            check(jumps[d] == 0, "R3", "jumps larger than one", jumps[d], 0);
            check(zbad[d] == 0, "R3", "nonzero offset at cycle end", zbad[d], 0);
        end
    endtask

    // R6 R5: mean over 32 cycles and the extremes of the length walk
    task automatic run_average(input int band);
        int cnt [2], last [2], sum [2], mn [2], mx [2];
        int n, lim, deep;
        deep = cur_deep;
        if (band == cur_band && cur_en_n == 0) deep = 1 - deep;
        apply_cfg(0, deep, band);
        lim = 3 + 34 * f_pmax(band);
        for (int d = 0; d < 2; d++) begin
            cnt[d] = 0; last[d] = 0; sum[d] = 0; mn[d] = 1 << 30; mx[d] = 0;
        end
        n = 0;
        while (n < lim && !(cnt[0] >= 33 && cnt[1] >= 33)) begin
            @(negedge clk);
            n++;
            for (int d = 0; d < 2; d++) begin
                if (done_a[d] && cnt[d] < 33) begin
                    if (cnt[d] > 0) begin
                        sum[d] += n - last[d];
                        if (n - last[d] < mn[d]) mn[d] = n - last[d];
                        if (n - last[d] > mx[d]) mx[d] = n - last[d];
                    end
                    last[d] = n;
                    cnt[d]++;
                end
            end
        end
        for (int d = 0; d < 2; d++) begin
            check(sum[d] == 32 * f_typ(band), "R6", "sum of 32 cycle lengths", sum[d], 32 * f_typ(band));
            check(mn[d] == f_pmin(band), "R5", "shortest cycle", mn[d], f_pmin(band));
            check(mx[d] == f_pmax(band), "R5", "longest cycle", mx[d], f_pmax(band));
        end
    endtask

    // R7 R8: disabled window
    task automatic run_disable();
        int nz [2], pulses [2], rise [2];
        int n, lim;
        apply_cfg(1, cur_deep, cur_band);
        lim = SETTLE + 3 + 2 * f_pmax(cur_band);
        for (int d = 0; d < 2; d++) begin nz[d] = 0; pulses[d] = 0; rise[d] = 0; end
        for (n = 1; n <= lim; n++) begin
            @(negedge clk);
            for (int d = 0; d < 2; d++) begin
                if (n >= 3 && ofs_a[d] != 8'sd0) nz[d]++;
                if (n >= 3 && done_a[d]) pulses[d]++;
                if (n >= 3 && rise[d] == 0 && rdy_a[d]) rise[d] = n;
            end
        end
        for (int d = 0; d < 2; d++) begin
            check(nz[d] == 0, "R7", "nonzero offset while off", nz[d], 0);
            check(pulses[d] == 0, "R7", "cycle pulses while off", pulses[d], 0);
            check(rise[d] == SETTLE + 3, "R8", "ready rise after disable", rise[d], SETTLE + 3);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", LIMIT, 0);
        finish_run();
    end

    initial begin
        int rise;
        void'($urandom(32'h5eed_0042));
        // R9: reset state
        repeat (4) begin
            @(negedge clk);
            for (int d = 0; d < 2; d++) begin
                check(ofs_a[d] == 8'sd0, "R9", "offset in reset", int'(ofs_a[d]), 0);
                check(!rdy_a[d] && !done_a[d], "R9", "flags in reset", int'(rdy_a[d]) + int'(done_a[d]), 0);
            end
        end
        rst_n = 1'b1;
        rise = 0;
        for (int n = 1; n <= SETTLE + 5; n++) begin
            @(negedge clk);
            if (rise == 0 && rdy_c && rdy_d) rise = n;
        end
        check(rise == SETTLE, "R9", "ready rise after reset", rise, SETTLE);

        // directed corners
        run_config(1, 3);
        run_config(0, 0);
        run_config(1, 1);
        run_config(0, 2);
        run_config(1, 0);

        run_disable();

        // constrained random settings
        for (int i = 0; i < 10; i++) begin
            run_config(int'($urandom_range(1, 0)), int'($urandom_range(3, 0)));
        end

        run_average(0);
        run_average(3);

        finish_run();
    end

endmodule